// File: doc/BRIEF.md
# Host Interrupt Wake Handshake Controller

This block sits on the host side of a serial link to a network coprocessor. It watches the coprocessor's active-low interrupt line. It also owns the active-low wake line that brings the coprocessor out of sleep. Only a high-to-low transition of the interrupt counts. Each transition is sorted by two things: the level of the host's slave-select output, and whether a wake handshake is open at that moment.

The block turns each transition into one of three outcomes:
- **Response ready:** a one-cycle pulse, raised when select is asserted.
- **Wake complete:** a one-cycle pulse that also closes the handshake, raised when a wake is pending and select is idle.
- **Callback pending:** a sticky flag, raised when select is idle and no wake is pending. Software polls the flag and clears it with a pulse.

The wake handshake starts on a request. The block drives the wake line low and waits for an interrupt transition. If none arrives within a parameterised number of cycles, it releases the line and reports a timeout. It does not retry. The default limit is 10 ms at a 250 MHz clock.

Top module: `host_irq_wake_ctrl`

## Requirements
- R1: After reset, `wake_n` is 1, `resp_ready`, `wake_done` and `wake_timeout` are 0, and `cb_pending` is 0.
- R2: `irq_n_in` passes through two synchroniser flops. An event caused by a high-to-low change of `irq_n_in` becomes visible at the outputs right after the third rising clock edge that follows the change, and not after the second.
- R3: Only a high-to-low transition of the synchronised interrupt is an event. Holding `irq_n_in` low for many cycles yields exactly one event. A low-to-high change yields none.
- R4: An event while `sel_n` is 0 gives a one-cycle `resp_ready` pulse. It leaves `cb_pending` and `wake_n` unchanged, even while a wake handshake is open.
- R5: An event while `sel_n` is 1 and `wake_n` is 1 sets `cb_pending`.
- R6: `cb_pending` stays set until a cycle in which `cb_clear` is 1. If a new callback event falls in the same cycle as `cb_clear`, the flag stays set.
- R7: `wake_req` sampled as 1 while `sel_n` is 1 and no handshake is open drives `wake_n` to 0 from the next cycle.
- R8: An event while `wake_n` is 0 and `sel_n` is 1 gives a one-cycle `wake_done` pulse. `wake_n` returns to 1 in the same cycle, and `cb_pending` is not touched.
- R9: With no terminating event, `wake_n` stays 0 for exactly `WAKE_TIMEOUT_CYC` cycles. It then returns to 1 together with a one-cycle `wake_timeout` pulse, and no new handshake starts by itself. An event in the final cycle counts as completion instead.
- R10: `wake_req` is ignored while a handshake is open (the timeout is not restarted) and while `sel_n` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_n_in | input | 1 | Coprocessor interrupt line, active low, asynchronous |
| sel_n | input | 1 | Host slave-select level, 0 = transaction in progress |
| wake_req | input | 1 | Request to start a wake handshake |
| cb_clear | input | 1 | Clears the callback-pending flag |
| wake_n | output | 1 | Wake line to the coprocessor, active low |
| resp_ready | output | 1 | One-cycle pulse: response available |
| wake_done | output | 1 | One-cycle pulse: wake handshake completed |
| wake_timeout | output | 1 | One-cycle pulse: wake handshake expired |
| cb_pending | output | 1 | Sticky flag: asynchronous callback waiting |

## Verification
The bench targets the following corner cases, and what a faulty design would show in each:

- **Long low interrupt:** a design that reacted to level would repeat events.
- **Clear in the same cycle as a new callback:** a wrong priority would drop the flag.
- **Second wake request mid-handshake:** a design that did not ignore it would restart the timer and expire late.
- **Request while select is asserted:** such a design would drive the wake line during a transfer.
- **Timeout boundary:** checked on the exact cycle, so an off-by-one limit or a retry after expiry shows up.

Randomised rounds then mix select levels, open handshakes, clears and pulse widths. A misrouted classification appears there as a pulse on the wrong output or a flag change that should not happen.

// File: rtl/host_irq_wake_ctrl.sv
module host_irq_wake_ctrl #(
  parameter int WAKE_TIMEOUT_CYC = 2500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_n_in,
  input  logic sel_n,
  input  logic wake_req,
  input  logic cb_clear,
  output logic wake_n,
  output logic resp_ready,
  output logic wake_done,
  output logic wake_timeout,
  output logic cb_pending
);
  localparam int CW = $clog2(WAKE_TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(WAKE_TIMEOUT_CYC - 1);

  logic [2:0]    irq_pipe;
  logic [CW-1:0] wait_cnt;
  logic          irq_fall, ev_resp, ev_wake, ev_cb, expire, start;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_pipe <= 3'b111;
    else        irq_pipe <= {irq_pipe[1:0], irq_n_in};

  assign irq_fall = irq_pipe[2] & ~irq_pipe[1];
  assign ev_resp  = irq_fall & ~sel_n;
  assign ev_wake  = irq_fall & sel_n & ~wake_n;
  assign ev_cb    = irq_fall & sel_n & wake_n;
  assign start    = wake_req & sel_n & wake_n;
  assign expire   = ~wake_n & (wait_cnt == LAST) & ~ev_wake;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wake_n       <= 1'b1;
      wait_cnt     <= '0;
      resp_ready   <= 1'b0;
      wake_done    <= 1'b0;
      wake_timeout <= 1'b0;
      cb_pending   <= 1'b0;
    end else begin
      if (start)                wake_n <= 1'b0;
      else if (ev_wake | expire) wake_n <= 1'b1;
      if (start)        wait_cnt <= '0;
      else if (!wake_n) wait_cnt <= wait_cnt + CW'(1);
      resp_ready   <= ev_resp;
      wake_done    <= ev_wake;
      wake_timeout <= expire;
      cb_pending   <= ev_cb | (cb_pending & ~cb_clear);
    end
endmodule

// File: rtl/host_irq_wake_chk.sv
module host_irq_wake_chk #(
  parameter int WAKE_TIMEOUT_CYC = 2500000
) (
  input logic clk,
  input logic rst_n,
  input logic sel_n,
  input logic wake_req,
  input logic cb_clear,
  input logic irq_fall,
  input logic wake_n,
  input logic resp_ready,
  input logic wake_done,
  input logic wake_timeout,
  input logic cb_pending
);
  int low_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       low_cnt <= 0;
    else if (!wake_n) low_cnt <= low_cnt + 1;
    else              low_cnt <= 0;

  // R9
  wake_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_cnt <= WAKE_TIMEOUT_CYC);
  // R9
  timeout_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_timeout |-> (wake_n && $past(!wake_n)));
  // R8
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |-> (wake_n && $past(!wake_n && sel_n)));
  // R4
  resp_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_ready |-> $past(!sel_n));
  // R3
  resp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_ready |=> !resp_ready);
  // R7
  wake_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake_n) |-> $past(wake_req && sel_n));
  // R5
  cb_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cb_pending) |-> $past(irq_fall && sel_n && wake_n));
  // R6
  cb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cb_pending) |-> $past(cb_clear));
  // R8
  event_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({resp_ready, wake_done}) && $onehot0({wake_done, wake_timeout}));
endmodule

bind host_irq_wake_ctrl host_irq_wake_chk #(.WAKE_TIMEOUT_CYC(WAKE_TIMEOUT_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wake_req(wake_req), .cb_clear(cb_clear),
  .irq_fall(irq_fall), .wake_n(wake_n), .resp_ready(resp_ready), .wake_done(wake_done),
  .wake_timeout(wake_timeout), .cb_pending(cb_pending)
);

// File: tb/host_irq_wake_ctrl_test.sv
module host_irq_wake_ctrl_test;
  localparam int TO = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic irq_n = 1'b1, sel_n = 1'b1, wake_req = 1'b0, cb_clear = 1'b0;
  logic wake_n, resp_ready, wake_done, wake_timeout, cb_pending;
  int n_chk = 0, n_bad = 0;
  int n_resp = 0, n_done = 0, n_to = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  host_irq_wake_ctrl #(.WAKE_TIMEOUT_CYC(TO)) uut (
    .clk(clk), .rst_n(rst_n), .irq_n_in(irq_n), .sel_n(sel_n), .wake_req(wake_req),
    .cb_clear(cb_clear), .wake_n(wake_n), .resp_ready(resp_ready), .wake_done(wake_done),
    .wake_timeout(wake_timeout), .cb_pending(cb_pending));

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      n_resp += int'(resp_ready);
      n_done += int'(wake_done);
      n_to   += int'(wake_timeout);
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_edge(int low_cycles);
    irq_n = 1'b0;
    step(low_cycles);
    irq_n = 1'b1;
    step(4);
  endtask

  function automatic int classify(logic s_n, logic wake_open);
    if (!s_n) return 0;
    if (wake_open) return 1;
    return 2;
  endfunction

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int r0, d0, t0;
    bit exp_cb;
    void'($urandom(32'h5EED1234));
    step(3);
    rst_n = 1'b1;
    step(2);
    chk("R1 wake_n", int'(wake_n), 1);
    chk("R1 pulses", int'(resp_ready) + int'(wake_done) + int'(wake_timeout), 0);
    chk("R1 cb_pending", int'(cb_pending), 0);

    // R2 latency and R3 level immunity, R4 response routing
    sel_n = 1'b0;
    r0 = n_resp;
    irq_n = 1'b0;
    step(2);
    chk("R2 not after second edge", int'(resp_ready), 0);
    step(1);
    chk("R2 after third edge", int'(resp_ready), 1);
    step(1);
    chk("R4 single pulse", int'(resp_ready), 0);
    step(20);
    chk("R3 held low one event", n_resp - r0, 1);
    chk("R4 no callback", int'(cb_pending), 0);
    irq_n = 1'b1;
    step(6);
    chk("R3 rising no event", n_resp - r0, 1);

    // R5 and R6
    sel_n = 1'b1;
    pulse_edge(2);
    chk("R5 cb set", int'(cb_pending), 1);
    chk("R5 no resp", n_resp - r0, 1);
    step(10);
    chk("R6 sticky", int'(cb_pending), 1);
    irq_n = 1'b0;
    step(2);
    cb_clear = 1'b1;
    step(1);
    cb_clear = 1'b0;
    chk("R6 set wins over clear", int'(cb_pending), 1);
    irq_n = 1'b1;
    step(4);
    cb_clear = 1'b1;
    step(1);
    cb_clear = 1'b0;
    chk("R6 clear", int'(cb_pending), 0);

    // R10 request during select
    sel_n = 1'b0;
    wake_req = 1'b1;
    step(1);
    wake_req = 1'b0;
    step(2);
    chk("R10 ignored with select", int'(wake_n), 1);
    sel_n = 1'b1;
    step(2);

    // R7 start, R9 timeout, R10 busy
    t0 = n_to;
    wake_req = 1'b1;
    step(1);
    wake_req = 1'b0;
    chk("R7 wake asserted", int'(wake_n), 0);
    step(5);
    wake_req = 1'b1;
    step(1);
    wake_req = 1'b0;
    step(TO - 7);
    chk("R10 no restart, still low", int'(wake_n), 0);
    chk("R9 no early timeout", int'(wake_timeout), 0);
    step(1);
    chk("R9 released", int'(wake_n), 1);
    chk("R9 timeout pulse", int'(wake_timeout), 1);
    step(1);
    chk("R9 pulse one cycle", int'(wake_timeout), 0);
    step(50);
    chk("R9 no retry", int'(wake_n), 1);
    chk("R9 single timeout", n_to - t0, 1);

    // R8 completion
    d0 = n_done;
    t0 = n_to;
    wake_req = 1'b1;
    step(1);
    wake_req = 1'b0;
    step(3);
    irq_n = 1'b0;
    step(3);
    chk("R8 done pulse", int'(wake_done), 1);
    chk("R8 wake released", int'(wake_n), 1);
    irq_n = 1'b1;
    step(TO + 5);
    chk("R8 no callback", int'(cb_pending), 0);
    chk("R8 no timeout", n_to - t0, 0);
    chk("R8 one done", n_done - d0, 1);

    // randomised rounds
    exp_cb = 1'b0;
    for (int i = 0; i < 60; i++) begin
      logic s;
      bit use_wake, clr;
      int cls;
      s = 1'($urandom_range(0, 1));
      use_wake = s && ($urandom_range(0, 1) == 1);
      clr = ($urandom_range(0, 2) == 0);
      sel_n = s;
      step(1);
      if (use_wake) begin
        wake_req = 1'b1;
        step(1);
        wake_req = 1'b0;
        step($urandom_range(1, 5));
        chk("R7 random wake low", int'(wake_n), 0);
      end
      r0 = n_resp; d0 = n_done; t0 = n_to;
      cls = classify(s, use_wake);
      pulse_edge($urandom_range(1, 6));
      if (cls == 2) exp_cb = 1'b1;
      chk("R4 random resp count", n_resp - r0, (cls == 0) ? 1 : 0);
      chk("R8 random done count", n_done - d0, (cls == 1) ? 1 : 0);
      chk("R5 random cb flag", int'(cb_pending), int'(exp_cb));
      chk("R9 random no timeout", n_to - t0, 0);
      chk("R8 random wake idle", int'(wake_n), 1);
      if (clr) begin
        cb_clear = 1'b1;
        step(1);
        cb_clear = 1'b0;
        exp_cb = 1'b0;
        chk("R6 random clear", int'(cb_pending), 0);
      end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule